// File: doc/BRIEF.md
# Reciprocal Square Root Seed Unit

This block turns one single-precision operand into a coarse estimate of 1/sqrt(x). The estimate is meant as the starting point of an iterative refinement carried out elsewhere. It is built from a 128-entry, 8-bit significand lookup and a short exponent subtraction. The result appears one clock after an accepted operand. Operands outside the normal positive range are mapped to fixed special results, and an invalid indication is raised where one applies.

An upstream stage presents the operand with a valid strobe. One cycle later the unit returns the 32-bit result with its own valid strobe, an invalid flag and an exception summary flag. When no operand is presented, the registered result and flags keep their previous values. The seed is not rounded and is not refined.

Top module: `rsqrt_seed`

## Requirements
- R1: For a positive normal operand with biased exponent E and fraction f, the lookup index is {bit 0 of (E-1), f[22:17]}. Seed entries include index 0 = 253, 1 = 252, 2 = 245, 3 = 244, 4 = 239, 5 = 238, 6 = 231, 7 = 230, 64 = 103, 126 = 3 and 127 = 2. The selected entry is placed in result bits [22:15].
- R2: For a positive normal operand, result bits [30:23] equal 0xBD minus floor((E-1)/2).
- R3: For a positive normal operand, result bit 31 is 0 and result bits [14:0] are zero.
- R4: Any NaN operand (exponent all ones, fraction nonzero), of either sign, gives 0x7FC00000. This takes priority over all other cases.
- R5: A zero or denormal operand (exponent 0) gives infinity with the operand's sign: 0x7F800000 or 0xFF800000. No flag is raised.
- R6: A negative operand that is a normal number or infinity gives 0x7FC00004 and raises both flags.
- R7: +infinity gives 0x00000000 with no flag.
- R8: The invalid flag and the summary flag are both 1 for a signaling NaN (fraction bit 22 = 0) and for the R6 cases. For every other operand, including a quiet NaN, both flags are 0.
- R9: The output valid strobe is the input valid strobe delayed by one clock, and the result belongs to that operand.
- R10: While reset (active low) is asserted, the valid strobe, the result and both flags are 0.
- R11: A cycle with input valid low leaves the result and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 32 | Seed or special result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_exc | output | 1 | Exception summary flag |

## Verification
The NaN test and the sign test can both apply to the same operand. A negative signaling NaN is sign-negative and NaN at once, so both the NaN result and the negative-operand invalid path compete in one cycle. Zero or denormal handling likewise competes with the sign test for a negative zero. The vectors include a negative quiet NaN, a negative signaling NaN and a negative denormal. They are judged on the exact output word and on the flags: NaN must win with 0x7FC00000, the flags must follow only the signaling bit, and a negative zero must give -infinity with no flag.

// File: rtl/rsqrt_seed.sv
module rsqrt_seed #(
  parameter int EW = 8,
  parameter int FW = 23,
  parameter int IW = 6,
  parameter int SW = 8,
  parameter logic [EW-1:0] EXP_K = 8'hBD,
  localparam int DW = 1 + EW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_op,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_invalid,
  output logic          out_exc
);
  localparam logic [DW-1:0] QNAN_W  = 32'h7FC00000;
  localparam logic [DW-1:0] NEGOP_W = 32'h7FC00004;

  function automatic logic [SW-2:0] half_seed(input logic [IW-1:0] k);
    case (k)
      6'd0:  half_seed = 7'd126; 6'd1:  half_seed = 7'd122; 6'd2:  half_seed = 7'd119; 6'd3:  half_seed = 7'd115;
      6'd4:  half_seed = 7'd112; 6'd5:  half_seed = 7'd108; 6'd6:  half_seed = 7'd105; 6'd7:  half_seed = 7'd102;
      6'd8:  half_seed = 7'd100; 6'd9:  half_seed = 7'd97;  6'd10: half_seed = 7'd94;  6'd11: half_seed = 7'd92;
      6'd12: half_seed = 7'd89;  6'd13: half_seed = 7'd87;  6'd14: half_seed = 7'd84;  6'd15: half_seed = 7'd82;
      6'd16: half_seed = 7'd80;  6'd17: half_seed = 7'd78;  6'd18: half_seed = 7'd76;  6'd19: half_seed = 7'd74;
      6'd20: half_seed = 7'd72;  6'd21: half_seed = 7'd70;  6'd22: half_seed = 7'd68;  6'd23: half_seed = 7'd66;
      6'd24: half_seed = 7'd65;  6'd25: half_seed = 7'd63;  6'd26: half_seed = 7'd61;  6'd27: half_seed = 7'd60;
      6'd28: half_seed = 7'd58;  6'd29: half_seed = 7'd57;  6'd30: half_seed = 7'd55;  6'd31: half_seed = 7'd54;
      6'd32: half_seed = 7'd51;  6'd33: half_seed = 7'd49;  6'd34: half_seed = 7'd46;  6'd35: half_seed = 7'd44;
      6'd36: half_seed = 7'd41;  6'd37: half_seed = 7'd39;  6'd38: half_seed = 7'd37;  6'd39: half_seed = 7'd35;
      6'd40: half_seed = 7'd33;  6'd41: half_seed = 7'd31;  6'd42: half_seed = 7'd29;  6'd43: half_seed = 7'd27;
      6'd44: half_seed = 7'd26;  6'd45: half_seed = 7'd24;  6'd46: half_seed = 7'd22;  6'd47: half_seed = 7'd21;
      6'd48: half_seed = 7'd19;  6'd49: half_seed = 7'd18;  6'd50: half_seed = 7'd16;  6'd51: half_seed = 7'd15;
      6'd52: half_seed = 7'd13;  6'd53: half_seed = 7'd12;  6'd54: half_seed = 7'd11;  6'd55: half_seed = 7'd9;
      6'd56: half_seed = 7'd8;   6'd57: half_seed = 7'd7;   6'd58: half_seed = 7'd6;   6'd59: half_seed = 7'd5;
      6'd60: half_seed = 7'd4;   6'd61: half_seed = 7'd3;   6'd62: half_seed = 7'd2;   default: half_seed = 7'd1;
    endcase
  endfunction

  logic          sgn;
  logic [EW-1:0] ex, ex_m1, new_ex;
  logic [FW-1:0] fr;
  logic          is_nan, is_snan, is_inf, is_zd, bad;
  logic [IW:0]   idx;
  logic [SW-1:0] seed;
  logic [DW-1:0] res_d;

  assign sgn     = in_op[DW-1];
  assign ex      = in_op[DW-2 -: EW];
  assign fr      = in_op[FW-1:0];
  assign is_nan  = (&ex) && (|fr);
  assign is_snan = is_nan && !fr[FW-1];
  assign is_inf  = (&ex) && !(|fr);
  assign is_zd   = (ex == '0);
  assign bad     = is_snan || (!is_nan && !is_zd && sgn);

  assign ex_m1  = ex - 1'b1;
  assign idx    = {ex_m1[0], fr[FW-1 -: IW]};
  assign seed   = {half_seed(idx[IW:1]), ~idx[0]};
  assign new_ex = EXP_K - {1'b0, ex_m1[EW-1:1]};

  always_comb begin
    if (is_nan)      res_d = QNAN_W;
    else if (is_zd)  res_d = {sgn, {EW{1'b1}}, {FW{1'b0}}};
    else if (sgn)    res_d = NEGOP_W;
    else if (is_inf) res_d = '0;
    else             res_d = {1'b0, new_ex, seed, {(FW-SW){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_exc     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_d;
        out_invalid <= bad;
        out_exc     <= bad;
      end
    end
  end
endmodule

module rsqrt_seed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_op,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_invalid,
  input logic        out_exc
);
  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_invalid) && $stable(out_exc)));
  p_nan_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&in_op[30:23]) && (|in_op[22:0])) |=> (out_result == 32'h7FC00000));
  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_result[30:23] != 8'hFF && out_result[30:23] != 8'h00) |-> (out_result[14:0] == 15'd0));
  p_flags_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_exc == out_invalid));
  p_inv_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result == 32'h7FC00004 || out_result == 32'h7FC00000));
endmodule

bind rsqrt_seed rsqrt_seed_chk u_chk (.*);

// File: tb/sim_rsqrt_seed.sv
module sim_rsqrt_seed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic        out_valid, out_invalid, out_exc;
  logic [31:0] out_result;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  rsqrt_seed u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
                 .out_valid(out_valid), .out_result(out_result),
                 .out_invalid(out_invalid), .out_exc(out_exc));

  // {requirement number, operand, expected result, expected flag}
  localparam int NV = 25;
  localparam logic [68:0] VEC [NV] = '{
    {4'd1, 32'h3F800000, 32'h3F7E8000, 1'b0}, // R1 index 0 -> 253, R2 E=127
    {4'd1, 32'h3F820000, 32'h3F7E0000, 1'b0}, // R1 index 1 -> 252
    {4'd1, 32'h3F840000, 32'h3F7A8000, 1'b0}, // R1 index 2 -> 245
    {4'd1, 32'h3F860000, 32'h3F7A0000, 1'b0}, // R1 index 3 -> 244
    {4'd1, 32'h3F880000, 32'h3F778000, 1'b0}, // R1 index 4 -> 239
    {4'd1, 32'h3F8E0000, 32'h3F730000, 1'b0}, // R1 index 7 -> 230
    {4'd1, 32'h40000000, 32'h3F338000, 1'b0}, // R1 index 64 -> 103
    {4'd1, 32'h407C0000, 32'h3F018000, 1'b0}, // R1 index 126 -> 3
    {4'd1, 32'h407E0000, 32'h3F010000, 1'b0}, // R1 index 127 -> 2
    {4'd2, 32'h40800000, 32'h3EFE8000, 1'b0}, // R2 E=129
    {4'd2, 32'h00800000, 32'h5EFE8000, 1'b0}, // R2 smallest normal
    {4'd2, 32'h7F000000, 32'h1FB38000, 1'b0}, // R2 largest exponent
    {4'd3, 32'h3F8001FF, 32'h3F7E8000, 1'b0}, // R3 low fraction bits do not leak
    {4'd4, 32'h7FC00000, 32'h7FC00000, 1'b0}, // R4 quiet NaN
    {4'd4, 32'hFFC00001, 32'h7FC00000, 1'b0}, // R4 negative quiet NaN
    {4'd8, 32'h7F800001, 32'h7FC00000, 1'b1}, // R8 signaling NaN
    {4'd8, 32'hFF800005, 32'h7FC00000, 1'b1}, // R8 negative signaling NaN
    {4'd5, 32'h00000000, 32'h7F800000, 1'b0}, // R5 +0
    {4'd5, 32'h80000000, 32'hFF800000, 1'b0}, // R5 -0
    {4'd5, 32'h00000001, 32'h7F800000, 1'b0}, // R5 denormal
    {4'd5, 32'h80400000, 32'hFF800000, 1'b0}, // R5 negative denormal
    {4'd6, 32'hBF800000, 32'h7FC00004, 1'b1}, // R6 -1.0
    {4'd6, 32'hFF800000, 32'h7FC00004, 1'b1}, // R6 -inf
    {4'd6, 32'h80800000, 32'h7FC00004, 1'b1}, // R6 smallest negative normal
    {4'd7, 32'h7F800000, 32'h00000000, 1'b0}  // R7 +inf
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'd0, out_valid}, 32'd0);
    check("R10 result", out_result, 32'd0);
    check("R10 flags", {30'd0, out_invalid, out_exc}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = VEC[i][64:33];
      @(negedge clk);
      check($sformatf("R%0d op=%h result", VEC[i][68:65], VEC[i][64:33]), out_result, VEC[i][32:1]);
      check($sformatf("R8 op=%h invalid", VEC[i][64:33]), {31'd0, out_invalid}, {31'd0, VEC[i][0]});
      check($sformatf("R8 op=%h summary", VEC[i][64:33]), {31'd0, out_exc}, {31'd0, VEC[i][0]});
      check("R9 valid", {31'd0, out_valid}, 32'd1);
    end

    // R11: flagged result must survive idle cycles with a changing operand
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = 32'hBF800000;
    @(negedge clk);
    in_valid = 1'b0;
    in_op    = 32'h3F800000;
    repeat (2) @(negedge clk);
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R11 held result", out_result, 32'h7FC00004);
    check("R11 held flags", {30'd0, out_invalid, out_exc}, 32'd3);

    // R9: back-to-back operands each land one cycle later
    in_valid = 1'b1;
    in_op    = 32'h7F800001;
    @(negedge clk);
    check("R9 first of pair", out_result, 32'h7FC00000);
    in_op = 32'h40800000;
    @(negedge clk);
    check("R9 second of pair", out_result, 32'h3EFE8000);
    check("R8 flag clears", {30'd0, out_invalid, out_exc}, 32'd0);
    in_valid = 1'b0;

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 result after reset", out_result, 32'd0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule